// File: doc/BRIEF.md
# Toggle-Derived Clock Enable Generator

This block turns a fast system clock into a slow square wave and a matching single-cycle enable strobe. Slow logic elsewhere in the chip stays on the system clock and advances only in cycles where the strobe is high. The divided wave is never used as a clock. It is meant for an indicator pin such as an LED, or for software-visible pacing.

A reloading down-counter counts system clock edges while the run input is high. When it reaches zero it reloads and the square wave inverts. A register holds the wave's value from the previous cycle. The strobe is the XOR of the live wave and that delayed copy, so it is high for exactly one cycle after every rising and every falling transition. The strobe rate is therefore twice the square-wave frequency. With the default reload of 10,000,000 and a 40 MHz system clock, the wave runs at roughly 2 Hz per full cycle pair of toggles and the strobe at twice that. The reload value is a parameter, and the counter width is derived from it.

Top module: `tce_enable_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the wave output is 0 and the strobe output is 0. With run held high, the first strobe appears in the cycle that begins RELOAD+1 clock edges after the edge that first sees reset low.
- R2: With run held high, successive strobes are exactly RELOAD+1 cycles apart.
- R3: The strobe is never high in two consecutive cycles.
- R4: The strobe is high in a cycle if and only if the wave output differs from its value in the previous cycle. This covers rising (0 to 1) and falling (1 to 0) transitions alike.
- R5: On an edge where run is low, the counter and the wave hold, and no strobe follows. When run returns high, counting resumes from the held value, so each wave transition takes exactly RELOAD+1 run-high edges.
- R6: Asserting reset in the middle of an interval discards the partial count. The next strobe comes a full RELOAD+1 edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; every register in the block uses it |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Counting is allowed on an edge only while this is high |
| wave_o | output | 1 | Divided square wave, registered |
| strobe_o | output | 1 | One-cycle enable pulse on each wave transition |

## Verification
The bench holds a queue of expected strobe cycles. These are derived from a count of run-high edges, so a counter that reloads one value off shows up as strobes that drift by a cycle per interval. A design that only detects rising transitions would miss every second queued strobe. Delaying the reference register by one cycle too many would produce two-cycle strobes, which the width check catches. Irregular run patterns and long pauses catch a counter that keeps running or restarts while paused. A mid-interval reset catches a partial count that leaks across reset.

// File: rtl/tce_pkg.sv
package tce_pkg;

  // Number of bits needed to hold values 0..top (at least one bit).
  function automatic int unsigned cnt_bits(input longint unsigned top);
    int unsigned b;
    b = 1;
    while (b < 63 && ((64'd1 << b) <= top)) b++;
    return b;
  endfunction

  // Interval in clock edges between two wave transitions.
  function automatic longint unsigned toggle_interval(input longint unsigned reload);
    return reload + 64'd1;
  endfunction

endpackage

// File: rtl/tce_reload_counter.sv
module tce_reload_counter #(
  parameter int unsigned RELOAD = 10_000_000,
  parameter int unsigned CW     = tce_pkg::cnt_bits(longint'(RELOAD))
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic expire_o
);

  localparam logic [CW-1:0] START = CW'(RELOAD);

  logic [CW-1:0] cnt_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= START;
    end else if (run_i) begin
      if (at_zero) cnt_q <= START;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  // Fires on the edge where the counter wraps; held off while paused.
  assign expire_o = run_i && at_zero;

endmodule

// File: rtl/tce_wave_toggle.sv
module tce_wave_toggle (
  input  logic clk_i,
  input  logic rst_i,
  input  logic flip_i,
  output logic wave_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i)       wave_o <= 1'b0;
    else if (flip_i) wave_o <= ~wave_o;
  end

endmodule

// File: rtl/tce_edge_strobe.sv
module tce_edge_strobe (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic strobe_o
);

  logic level_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) level_d <= 1'b0;
    else       level_d <= level_i;
  end

  // Both inputs of the XOR are flops on clk_i, so the pulse is one period.
  assign strobe_o = level_i ^ level_d;

endmodule

// File: rtl/tce_enable_gen.sv
module tce_enable_gen #(
  parameter int unsigned RELOAD = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic wave_o,
  output logic strobe_o
);

  localparam int unsigned CW = tce_pkg::cnt_bits(longint'(RELOAD));

  logic expire;
  logic wave;

  tce_reload_counter #(
    .RELOAD (RELOAD),
    .CW     (CW)
  ) cnt_u (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run_i),
    .expire_o (expire)
  );

  tce_wave_toggle wave_u (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .flip_i (expire),
    .wave_o (wave)
  );

  tce_edge_strobe edge_u (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .level_i  (wave),
    .strobe_o (strobe_o)
  );

  assign wave_o = wave;

endmodule

// File: rtl/tce_enable_gen_chk.sv
module tce_enable_gen_chk (
  input logic clk_i,
  input logic rst_i,
  input logic run_i,
  input logic wave_o,
  input logic strobe_o
);

  // R3: a strobe never stretches into a second cycle
  p_single_cycle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |=> !strobe_o);

  // R4: strobe marks exactly the cycles where the wave has just changed
  p_strobe_edge_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o == (wave_o != $past(wave_o)));

  // R5: a paused edge leaves the wave unchanged
  p_hold_paused_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> $stable(wave_o));

  // R5: no strobe follows a paused edge
  p_paused_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !strobe_o);

  // R1: release from reset is quiet
  p_quiet_release_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (!strobe_o && !wave_o));

endmodule

bind tce_enable_gen tce_enable_gen_chk chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .run_i    (run_i),
  .wave_o   (wave_o),
  .strobe_o (strobe_o)
);

// File: tb/tce_enable_gen_tb_top.sv
module tce_enable_gen_tb_top;

  localparam int unsigned RELOAD = 6;
  localparam int          SPAN   = RELOAD + 1;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic run_i = 1'b1;
  logic wave_o;
  logic strobe_o;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  int rem    = SPAN;
  bit done   = 1'b0;
  int exp_q[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  tce_enable_gen #(.RELOAD(RELOAD)) dut_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run_i),
    .wave_o   (wave_o),
    .strobe_o (strobe_o)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Scoreboard model: count run-high edges; every SPAN of them a strobe is due.
  task automatic account();
    if (run_i) begin
      rem--;
      if (rem == 0) begin
        exp_q.push_back(cyc + 1);
        rem = SPAN;
      end
    end
  endtask

  task automatic step(input bit run);
    @(negedge clk_i);
    run_i = run;
    account();
  endtask

  // R1/R6: reset for n cycles, then release with run high
  task automatic do_reset(input int n);
    @(negedge clk_i);
    rst_i = 1'b1;
    exp_q.delete();
    repeat (n) @(negedge clk_i);
    rst_i = 1'b0;
    run_i = 1'b1;
    rem   = SPAN;
    account();
  endtask

  // Monitor
  initial begin
    bit prev_wave = 1'b0;
    bit prev_strobe = 1'b0;
    bit prev_rst = 1'b1;
    forever begin
      @(negedge clk_i);
      #1;
      if (done) break;
      if (cyc > 0) begin
        if (rst_i) begin
          if (prev_rst) begin
            check("R1 wave in reset", wave_o == 1'b0, int'(wave_o), 0);
            check("R1 strobe in reset", strobe_o == 1'b0, int'(strobe_o), 0);
          end
        end else begin
          if (prev_rst)
            check("R1 quiet release", !strobe_o && !wave_o, int'(strobe_o), 0);
          check("R4 strobe iff transition", strobe_o == (wave_o != prev_wave),
                int'(strobe_o), int'(wave_o != prev_wave));
          if (strobe_o) begin
            check("R3 strobe width", !prev_strobe, 2, 1);
            if (exp_q.size() == 0) begin
              check("R5 unexpected strobe", 1'b0, cyc, -1);
            end else begin
              int e;
              e = exp_q.pop_front();
              check("R2 strobe cycle", e == cyc, cyc, e);
            end
          end
          while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            check("R2 missed strobe", 1'b0, cyc, exp_q[0]);
            void'(exp_q.pop_front());
          end
        end
      end
      prev_wave   = wave_o;
      prev_strobe = strobe_o;
      prev_rst    = rst_i;
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected <50000", cyc);
      summary();
      $finish;
    end
  end

  // Driver
  initial begin
    repeat (3) @(negedge clk_i);
    do_reset(1);
    // R1/R2: free run, several full wave periods (rising and falling)
    for (int i = 0; i < 8 * SPAN; i++) step(1'b1);
    // R5: irregular run pattern
    for (int i = 0; i < 60; i++) step((i % 3) != 0);
    // R5: long pause, then resume
    for (int i = 0; i < 15; i++) step(1'b0);
    for (int i = 0; i < 3 * SPAN; i++) step(1'b1);
    // R5: short alternating pauses
    for (int i = 0; i < 40; i++) step(i[0]);
    // R6: reset in the middle of an interval
    for (int i = 0; i < 4; i++) step(1'b1);
    do_reset(2);
    for (int i = 0; i < 4 * SPAN; i++) step(1'b1);
    // drain with run low so nothing new becomes due
    for (int i = 0; i < 3; i++) step(1'b0);
    @(negedge clk_i);
    #2;
    check("R2 all expected strobes seen", exp_q.size() == 0, exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule